// File: doc/BRIEF.md
# Single-Slope Ramp Converter Sequencer

This block sequences a single-slope integrating converter made of an external current source, a capacitor and a comparator behind a four-way analog multiplexer. The host picks one of four potentiometer inputs through a 2-bit channel field, then pulses a start strobe. The block drives the capacitor-discharge output high for a programmable number of clock cycles. It then releases the capacitor and, in the same clock edge, clears and starts an 8-bit timer.

The capacitor charges until its voltage passes the selected potentiometer voltage. At that point the comparator output falls. The comparator input is asynchronous, so it passes through a two-flop synchroniser before a falling-edge detector. On a detected fall the block freezes the timer and raises an active-high interrupt. The frozen count is the conversion result, and the host reads it when it chooses.

The result saturates at 255. If the timer reaches 255 without a comparator fall, the block sets an overflow flag. A result-read strobe clears the interrupt.

Top module: `ramp_adc_seq`

## Requirements
- R1: A start strobe sampled while idle raises `capReset` at the next clock edge and holds it high for exactly `dischLen` cycles, where `dischLen` is the last value written through `cfgWe`/`cfgLen`. A written length of 0 behaves as 1.
- R2: After reset the discharge length is 64 cycles.
- R3: `muxSel` holds the last accepted 2-bit channel write. Value n selects potentiometer input n, for n from 0 to 3.
- R4: The timer is 0 at the edge that releases `capReset`. The result equals the number of rising edges after that release, up to and including the second edge that samples `compIn` low. This count reflects the two-flop synchroniser latency.
- R5: `irq` rises at the edge after the fall is detected. From then on `result` stays constant until the next accepted start.
- R6: If the timer holds 255 at an edge with no detected fall, conversion stops with `result` = 255, `overflow` = 1 and `irq` = 1. A fall detected at that same edge wins: `overflow` stays 0.
- R7: A `resultRd` strobe while idle clears `irq` at the next edge.
- R8: A start strobe during the discharge or ramp phase is ignored. The phase, the timer and `capReset` are unaffected.
- R9: Channel writes take effect while idle or discharging. Writes during the ramp phase are ignored.
- R10: Reset leaves `capReset`, `irq`, `overflow`, `muxSel` and `result` all at 0.
- R11: An accepted start clears `overflow` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Load discharge length |
| cfgLen | input | 8 | Discharge length in cycles (0 behaves as 1) |
| chanWe | input | 1 | Channel write strobe |
| chanData | input | 2 | Channel number |
| startPulse | input | 1 | Start conversion strobe |
| resultRd | input | 1 | Result-read strobe; clears the interrupt |
| compIn | input | 1 | Asynchronous comparator output; falls when the ramp passes the input |
| capReset | output | 1 | Capacitor discharge control, active high |
| muxSel | output | 2 | Analog multiplexer select |
| result | output | 8 | Frozen timer value |
| irq | output | 1 | Conversion-complete interrupt, active high |
| overflow | output | 1 | Timer saturated without a comparator fall |

## Verification
The bench sweeps the comparator fall delay across every ramp position from 0 to 254 cycles, plus a run where the comparator never falls. In each case it compares the result with the delay plus two cycles of synchroniser latency. A design that miscounts the synchroniser stages, or starts the timer one edge late, would be off by a constant on every sample. The cases at delay 253 and delay 254 separate a fall that coincides with saturation from a true overflow; getting the priority wrong flips the overflow flag in one of them. The bench also measures the discharge width at the reset default, at a short programmed value and at zero, and issues start and channel writes in the middle of a ramp. A design that restarted or re-routed there would show a fresh `capReset` pulse, a changed `muxSel` or a wrong count.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DISCH = 2'd1,
    PH_RAMP  = 2'd2
  } phase_e;

  typedef struct packed {
    logic dischLoad;
    logic dischDec;
    logic timerClr;
    logic timerInc;
    logic chanLoad;
    logic irqSet;
    logic irqClr;
    logic ovfSet;
    logic ovfClr;
  } ctlStrobes_t;

endpackage

// File: rtl/ramp_adc_sync.sv
module ramp_adc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic fallSeen
);
  logic [STAGES-1:0] chainQ;
  logic              lastQ;

  // Comparator idles high, so the chain resets high to avoid a false fall.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ <= '1;
      lastQ  <= 1'b1;
    end else begin
      chainQ <= {chainQ[STAGES-2:0], asyncIn};
      lastQ  <= chainQ[STAGES-1];
    end
  end

  assign fallSeen = lastQ & ~chainQ[STAGES-1];
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        resultRd,
  input  logic        chanWe,
  input  logic        dischZero,
  input  logic        timerFull,
  input  logic        compFall,
  output ctlStrobes_t strb,
  output phase_e      phase,
  output logic        capReset
);
  phase_e phaseNext;

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    strb.irqClr = resultRd;
    unique case (phase)
      PH_IDLE: begin
        strb.chanLoad = chanWe;
        if (startPulse) begin
          strb.dischLoad = 1'b1;
          strb.ovfClr    = 1'b1;
          strb.irqClr    = 1'b1;
          phaseNext      = PH_DISCH;
        end
      end
      PH_DISCH: begin
        strb.chanLoad = chanWe;
        if (dischZero) begin
          strb.timerClr = 1'b1;
          phaseNext     = PH_RAMP;
        end else begin
          strb.dischDec = 1'b1;
        end
      end
      PH_RAMP: begin
        if (compFall) begin
          strb.irqSet = 1'b1;
          phaseNext   = PH_IDLE;
        end else if (timerFull) begin
          strb.irqSet = 1'b1;
          strb.ovfSet = 1'b1;
          phaseNext   = PH_IDLE;
        end else begin
          strb.timerInc = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      capReset <= 1'b0;
    end else begin
      phase    <= phaseNext;
      capReset <= (phaseNext == PH_DISCH);
    end
  end
endmodule

// File: rtl/ramp_adc_dpath.sv
module ramp_adc_dpath
  import ramp_adc_pkg::*;
#(
  parameter int TW      = 8,
  parameter int LW      = 8,
  parameter int CW      = 2,
  parameter int DEF_LEN = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strb,
  input  logic          cfgWe,
  input  logic [LW-1:0] cfgLen,
  input  logic [CW-1:0] chanData,
  output logic          dischZero,
  output logic          timerFull,
  output logic [CW-1:0] muxSel,
  output logic [TW-1:0] result,
  output logic          irq,
  output logic          overflow
);
  localparam logic [LW-1:0] LEN_RST = LW'(DEF_LEN);
  localparam logic [TW-1:0] T_MAX   = '1;

  logic [LW-1:0] lenQ;
  logic [LW-1:0] effLen;
  logic [LW-1:0] dischCnt;
  logic [TW-1:0] timerQ;

  assign effLen = (lenQ == '0) ? LW'(1) : lenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      lenQ <= LEN_RST;
    else if (cfgWe) lenQ <= cfgLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dischCnt <= '0;
    else if (strb.dischLoad) dischCnt <= effLen - LW'(1);
    else if (strb.dischDec)  dischCnt <= dischCnt - LW'(1);
  end
  assign dischZero = (dischCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timerQ <= '0;
    else if (strb.timerClr) timerQ <= '0;
    else if (strb.timerInc) timerQ <= timerQ + TW'(1);
  end
  assign timerFull = (timerQ == T_MAX);
  assign result    = timerQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              muxSel <= '0;
    else if (strb.chanLoad) muxSel <= chanData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq      <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (strb.irqSet)      irq <= 1'b1;
      else if (strb.irqClr) irq <= 1'b0;
      if (strb.ovfSet)      overflow <= 1'b1;
      else if (strb.ovfClr) overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
  import ramp_adc_pkg::*;
#(
  parameter int TW          = 8,
  parameter int LW          = 8,
  parameter int CW          = 2,
  parameter int DEF_LEN     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [LW-1:0] cfgLen,
  input  logic          chanWe,
  input  logic [CW-1:0] chanData,
  input  logic          startPulse,
  input  logic          resultRd,
  input  logic          compIn,
  output logic          capReset,
  output logic [CW-1:0] muxSel,
  output logic [TW-1:0] result,
  output logic          irq,
  output logic          overflow
);
  ctlStrobes_t strb;
  phase_e      phase;
  logic        dischZero;
  logic        timerFull;
  logic        compFall;

  ramp_adc_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(compIn), .fallSeen(compFall)
  );

  ramp_adc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .resultRd(resultRd),
    .chanWe(chanWe), .dischZero(dischZero), .timerFull(timerFull),
    .compFall(compFall), .strb(strb), .phase(phase), .capReset(capReset)
  );

  ramp_adc_dpath #(.TW(TW), .LW(LW), .CW(CW), .DEF_LEN(DEF_LEN)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWe(cfgWe), .cfgLen(cfgLen),
    .chanData(chanData), .dischZero(dischZero), .timerFull(timerFull),
    .muxSel(muxSel), .result(result), .irq(irq), .overflow(overflow)
  );
endmodule

// File: rtl/ramp_adc_seq_chk.sv
module ramp_adc_seq_chk
  import ramp_adc_pkg::*;
#(
  parameter int TW = 8,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          startPulse,
  input logic          resultRd,
  input logic          capReset,
  input logic [CW-1:0] muxSel,
  input logic [TW-1:0] result,
  input logic          irq,
  input logic          overflow,
  input phase_e        phase
);
  a_r1_discharge_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capReset) |-> $past(startPulse));

  a_r5_result_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |=> $stable(result));

  a_r6_ovf_saturated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> (result == '1 && irq));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (resultRd && phase == PH_IDLE) |=> !irq);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && phase == PH_RAMP) |=> !capReset);

  a_r9_chan_locked: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RAMP) |=> $stable(muxSel));
endmodule

bind ramp_adc_seq ramp_adc_seq_chk #(.TW(TW), .CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .resultRd(resultRd),
  .capReset(capReset), .muxSel(muxSel), .result(result), .irq(irq),
  .overflow(overflow), .phase(phase)
);

// File: tb/ramp_adc_seq_tb.sv
`timescale 1ns/1ps
module ramp_adc_seq_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgLen = '0;
  logic       chanWe = 1'b0;
  logic [1:0] chanData = '0;
  logic       startPulse = 1'b0;
  logic       resultRd = 1'b0;
  logic       compIn = 1'b1;
  logic       capReset;
  logic [1:0] muxSel;
  logic [7:0] result;
  logic       irq;
  logic       overflow;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  int  lastLen;
  int  lastRes;
  int  lastOvf;

  always #2.5 clk = ~clk;

  ramp_adc_seq dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgLen(cfgLen), .chanWe(chanWe),
    .chanData(chanData), .startPulse(startPulse), .resultRd(resultRd),
    .compIn(compIn), .capReset(capReset), .muxSel(muxSel), .result(result),
    .irq(irq), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Start, measure discharge width, drop comparator d cycles after release
  // (or never), wait for irq, record result.
  task automatic runConv(input int d, input bit drop, input bit midStart, input bit midChan);
    int n;
    int w;
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    n = 0;
    while (capReset && n < 1000) begin n++; @(negedge clk); end
    lastLen = n;
    if (midStart) begin
      startPulse = 1'b1; @(negedge clk); startPulse = 1'b0;
      chk(capReset == 1'b0, "R8 start in ramp", capReset, 0);
      d = d - 1;
    end
    if (midChan) begin
      chanWe = 1'b1; chanData = 2'd1; @(negedge clk); chanWe = 1'b0;
      chk(muxSel == 2'd3, "R9 chan write in ramp", muxSel, 3);
      d = d - 1;
    end
    if (drop) begin
      repeat (d) @(negedge clk);
      compIn = 1'b0;
    end
    w = 0;
    while (!irq && w < 400) begin w++; @(negedge clk); end
    compIn = 1'b1;
    lastRes = result;
    lastOvf = overflow;
    chk(irq == 1'b1, "R5 irq after conversion", irq, 1);
    repeat (4) @(negedge clk);
    chk(result == lastRes, "R5 result frozen", result, lastRes);
    resultRd = 1'b1; @(negedge clk); resultRd = 1'b0;
    chk(irq == 1'b0, "R7 read clears irq", irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(capReset == 0, "R10 capReset", capReset, 0);
    chk(irq == 0, "R10 irq", irq, 0);
    chk(overflow == 0, "R10 overflow", overflow, 0);
    chk(muxSel == 0, "R10 muxSel", muxSel, 0);
    chk(result == 0, "R10 result", result, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 default discharge width
    runConv(10, 1'b1, 1'b0, 1'b0);
    chk(lastLen == 64, "R2 default length", lastLen, 64);
    chk(lastRes == 12, "R4 result d=10", lastRes, 12);

    // R1 programmed widths, zero behaves as one
    cfgWe = 1'b1; cfgLen = 8'd0; @(negedge clk); cfgWe = 1'b0;
    runConv(5, 1'b1, 1'b0, 1'b0);
    chk(lastLen == 1, "R1 zero length", lastLen, 1);
    cfgWe = 1'b1; cfgLen = 8'd4; @(negedge clk); cfgWe = 1'b0;
    runConv(5, 1'b1, 1'b0, 1'b0);
    chk(lastLen == 4, "R1 length 4", lastLen, 4);

    // R3 channel select in idle, every value
    for (int c = 0; c < 4; c++) begin
      chanWe = 1'b1; chanData = 2'(c); @(negedge clk); chanWe = 1'b0;
      chk(muxSel == 2'(c), "R3 mux select", muxSel, c);
    end

    // R4 / R6 sweep of comparator fall position
    for (int d = 0; d <= 254; d++) begin
      runConv(d, 1'b1, 1'b0, 1'b0);
      if (d + 2 <= 255) begin
        chk(lastRes == d + 2, "R4 count", lastRes, d + 2);
        chk(lastOvf == 0, "R6 no overflow on coincident fall", lastOvf, 0);
      end else begin
        chk(lastRes == 255, "R6 saturate", lastRes, 255);
        chk(lastOvf == 1, "R6 overflow flag", lastOvf, 1);
      end
    end

    // R6 comparator never falls
    runConv(0, 1'b0, 1'b0, 1'b0);
    chk(lastRes == 255, "R6 no fall result", lastRes, 255);
    chk(lastOvf == 1, "R6 no fall overflow", lastOvf, 1);

    // R11 accepted start clears overflow
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    chk(overflow == 0, "R11 start clears overflow", overflow, 0);
    // R9 channel write during discharge accepted
    chanWe = 1'b1; chanData = 2'd3; @(negedge clk); chanWe = 1'b0;
    chk(muxSel == 3, "R9 chan write in discharge", muxSel, 3);
    compIn = 1'b0; repeat (3) @(negedge clk);
    while (!irq) @(negedge clk);
    compIn = 1'b1;
    resultRd = 1'b1; @(negedge clk); resultRd = 1'b0;
    repeat (4) @(negedge clk);

    // R8 start during ramp ignored, R9 channel locked during ramp
    runConv(40, 1'b1, 1'b1, 1'b1);
    chk(lastLen == 4, "R8 single discharge", lastLen, 4);
    chk(lastRes == 42, "R8 count unaffected", lastRes, 42);
    chk(muxSel == 3, "R9 mux kept", muxSel, 3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule